// File: doc/BRIEF.md
# Tick-Driven Count/Compare Timer with Routed Interrupt

This is a system timer of the kind that sits beside a processor core. It holds a free-running count register and a compare register, both `CNT_W` bits wide (32 by default). The count advances by one on each clock cycle in which `tick_i` is high. A divider elsewhere on the chip might pulse `tick_i` every second core cycle, for example.

When a tick moves the count onto the compare value, the timer latches a pending state. It then drives exactly one of `NUM_LINES` interrupt outputs. A routing field in the control register picks which output. The pending state, and with it the interrupt level, stays set until software writes the compare register. Writing compare is the only acknowledge.

A freeze bit in the control register stops the count and blocks any match. Count loads still take effect while frozen. A build parameter, `NEW_REV`, selects the newer revision. Only that revision exposes the pending state as a readable status bit.

Access goes through a single-cycle write strobe and a combinational read select. Both use the same 2-bit register select:

| Code | Register |
|------|----------|
| 0 | count |
| 1 | compare |
| 2 | control |
| 3 | status |

In the control register, bit 0 is the freeze bit and bits [6:4] hold the routing field. In the status register, bit 0 is the pending bit.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, count, compare, freeze and the routing field are 0, the pending state is clear, and every bit of `irq_o` is low.
- R2: On each rising clock edge with `tick_i` high, freeze clear and no count write, count becomes (count + 1) mod 2^CNT_W. With `tick_i` low, count holds.
- R3: A write with select 0 loads count at that edge. A count write takes precedence over a tick in the same cycle, and later ticks count on from the loaded value.
- R4: A match occurs when a tick advances count to a value equal to compare. At the edge where count takes that value, the pending state sets and `irq_o` rises.
- R5: Loading count or compare so that the two become equal does not raise a match. After compare is written equal to count, the next match comes only after 2^CNT_W further ticks.
- R6: Any write with select 1 clears the pending state and lowers `irq_o` at that edge. This holds even if a match occurs in the same cycle.
- R7: The interrupt is a level. Once pending, it stays set through further ticks and later matches until a compare write.
- R8: While control bit 0 (freeze) is 1:
  - ticks do not change count;
  - a read of select 0 returns the held value;
  - a count write loads directly;
  - no match is raised.
- R9: While pending, only `irq_o[route]` is high, where route is control bits [6:4]. Changing the routing field moves the level to the newly selected line.
- R10: With NEW_REV=1, reading select 3 returns the pending state in bit 0. With NEW_REV=0, that read returns 0, while `irq_o` behaves identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count advance enable for this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 count, 1 compare, 2 control, 3 status (ignored) |
| wr_data_i | input | CNT_W | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as `wr_sel_i` |
| rd_data_o | output | CNT_W | Read data for the register chosen by `rd_sel_i` (combinational) |
| irq_o | output | NUM_LINES | Routed interrupt levels, at most one high |

## Verification
Every register update is due one edge after the cycle that requests it:
- a write or tick presented before an edge shows on `rd_data_o` right after that edge;
- a match raises `irq_o` at the same edge where count lands on compare;
- a compare write lowers `irq_o` at its own edge.

The bench changes inputs 1 ns after a rising edge. It samples after that settle time and before the next edge, so each check sees exactly the edges its stimulus requested. A second instance built with NEW_REV=0 receives the same stimulus, which lets the bench compare the two revisions' interrupt lines and status reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_COUNT   = 2'd0,
    REG_COMPARE = 2'd1,
    REG_CTRL    = 2'd2,
    REG_STATUS  = 2'd3
  } tmr_reg_e;

  localparam int unsigned CTRL_FRZ_BIT   = 0;
  localparam int unsigned CTRL_ROUTE_LSB = 4;
  localparam int unsigned STAT_PEND_BIT  = 0;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o,
  output logic             adv_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_inc_o = cnt_q + ONE;
  // load wins over tick; freeze blocks advance
  assign adv_o     = tick_i & ~freeze_i & ~load_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_o)  cnt_q <= cnt_inc_o;
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !freeze_i && !load_i) |=> cnt_q == $past(cnt_q) + ONE);
  a_r8_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_inc_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             pend_q;
  logic             hit;

  // match only on an advancing tick, never on a load
  assign hit    = adv_i && (cnt_inc_i == cmp_q);
  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (cmp_we_i) pend_q <= 1'b0;
    else if (hit)      pend_q <= 1'b1;
  end

  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> !pend_q);
  a_r7_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cmp_we_i) |=> pend_q);
  a_r8_no_fire_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ROUTE_W   = 3
) (
  input  logic               pend_i,
  input  logic [ROUTE_W-1:0] route_i,
  output logic [NUM_LINES-1:0] irq_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign irq_o[i] = pend_i && (route_i == ROUTE_W'(i));
  end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_LINES = 8,
  parameter bit          NEW_REV   = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_sel_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [1:0]           rd_sel_i,
  output logic [CNT_W-1:0]     rd_data_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned ROUTE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic               cnt_we, cmp_we, ctl_we;
  logic               freeze_q;
  logic [ROUTE_W-1:0] route_q;
  logic [CNT_W-1:0]   cnt, cnt_inc, cmp;
  logic               adv, pend, stat_pend;

  assign cnt_we = wr_en_i && (tmr_reg_e'(wr_sel_i) == REG_COUNT);
  assign cmp_we = wr_en_i && (tmr_reg_e'(wr_sel_i) == REG_COMPARE);
  assign ctl_we = wr_en_i && (tmr_reg_e'(wr_sel_i) == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      route_q  <= '0;
    end else if (ctl_we) begin
      freeze_q <= wr_data_i[CTRL_FRZ_BIT];
      route_q  <= wr_data_i[CTRL_ROUTE_LSB +: ROUTE_W];
    end
  end

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .freeze_i   (freeze_q),
    .load_i     (cnt_we),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt),
    .cnt_inc_o  (cnt_inc),
    .adv_o      (adv)
  );

  tmr_match #(.CNT_W(CNT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .cnt_inc_i (cnt_inc),
    .cmp_we_i  (cmp_we),
    .cmp_val_i (wr_data_i),
    .cmp_o     (cmp),
    .pend_o    (pend)
  );

  tmr_route #(.NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)) u_route (
    .pend_i  (pend),
    .route_i (route_q),
    .irq_o   (irq_o)
  );

  if (NEW_REV) begin : g_stat_new
    assign stat_pend = pend;
  end else begin : g_stat_old
    assign stat_pend = 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (tmr_reg_e'(rd_sel_i))
      REG_COUNT:   rd_data_o = cnt;
      REG_COMPARE: rd_data_o = cmp;
      REG_CTRL: begin
        rd_data_o[CTRL_FRZ_BIT]               = freeze_q;
        rd_data_o[CTRL_ROUTE_LSB +: ROUTE_W] = route_q;
      end
      REG_STATUS:  rd_data_o[STAT_PEND_BIT] = stat_pend;
      default:     rd_data_o = '0;
    endcase
  end

  a_r9_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  a_r4_hit_on_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[route_q]) && $stable(route_q) |-> cnt == cmp);
  a_r5_load_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we && !pend) |=> !pend);
endmodule

// File: tb/tick_match_timer_bench.sv
module tick_match_timer_bench;
  localparam int unsigned W = 8;
  localparam logic [1:0] S_CNT = 2'd0, S_CMP = 2'd1, S_CTL = 2'd2, S_STA = 2'd3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [1:0]   rd_sel_i = '0;
  logic [W-1:0] rd_data_o, rd_data_l;
  logic [7:0]   irq_o, irq_l;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tick_match_timer #(.CNT_W(W), .NUM_LINES(8), .NEW_REV(1'b1)) u_tick_match_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o));

  tick_match_timer #(.CNT_W(W), .NUM_LINES(8), .NEW_REV(1'b0)) u_tick_match_timer_legacy (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_l), .irq_o(irq_l));

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = W'(d);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n);
    tick_i = 1'b1;
    repeat (n) step();
    tick_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v, output int vl);
    rd_sel_i = s;
    #1;
    v = int'(rd_data_o);
    vl = int'(rd_data_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int v, vl;
    step(); step();
    // R1 reset state
    rd(S_CNT, v, vl); chk("R1", "count", v, 0);
    rd(S_CMP, v, vl); chk("R1", "compare", v, 0);
    rd(S_CTL, v, vl); chk("R1", "control", v, 0);
    rd(S_STA, v, vl); chk("R1", "status", v, 0);
    chk("R1", "irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    step();

    // R2 count advance and gating
    run(10);
    rd(S_CNT, v, vl); chk("R2", "count after 10 ticks", v, 10);
    repeat (5) step();
    rd(S_CNT, v, vl); chk("R2", "count without tick", v, 10);

    // R2/R4 wrap onto compare=0, route 0
    wr(S_CNT, 250);
    run(10);
    rd(S_CNT, v, vl); chk("R2", "wrapped count", v, 4);
    chk("R4", "irq after match at 0", int'(irq_o), 1);
    wr(S_CMP, 200);
    chk("R6", "irq after compare write", int'(irq_o), 0);

    // R3 load beats tick
    tick_i = 1'b1;
    wr(S_CNT, 8'h80);
    tick_i = 1'b0;
    rd(S_CNT, v, vl); chk("R3", "load over tick", v, 8'h80);
    run(3);
    rd(S_CNT, v, vl); chk("R3", "count from load", v, 8'h83);

    // R4/R9/R10 sweep over every compare value and route
    for (int c = 0; c < 256; c++) begin
      int r;
      r = c % 8;
      wr(S_CTL, r << 4);
      wr(S_CNT, (c - 3) & 8'hFF);
      wr(S_CMP, c);
      run(2);
      chk("R4", "no irq before match", int'(irq_o), 0);
      run(1);
      rd(S_CNT, v, vl); chk("R4", "count at match", v, c);
      chk("R9", "routed line", int'(irq_o), 1 << r);
      chk("R10", "legacy irq equal", int'(irq_l), 1 << r);
      rd(S_STA, v, vl);
      chk("R10", "status pending new rev", v, 1);
      chk("R10", "status zero legacy", vl, 0);
    end

    // R5 compare written equal to count: full wrap needed (count=255, route 7)
    wr(S_CMP, 255);
    chk("R6", "cleared", int'(irq_o), 0);
    run(255);
    rd(S_CNT, v, vl); chk("R5", "count before wrap match", v, 254);
    chk("R5", "no early irq", int'(irq_o), 0);
    run(1);
    chk("R5", "irq after full wrap", int'(irq_o), 1 << 7);

    // R7 level holds through another full wrap
    run(256);
    chk("R7", "irq held", int'(irq_o), 1 << 7);
    rd(S_STA, v, vl); chk("R7", "status held", v, 1);

    // R5 count loaded equal to compare does not fire
    wr(S_CMP, 40);
    wr(S_CNT, 40);
    chk("R5", "no irq on count load", int'(irq_o), 0);
    run(1);
    chk("R5", "no irq after next tick", int'(irq_o), 0);

    // R6 compare write in the same cycle as a match
    wr(S_CMP, 60);
    wr(S_CNT, 58);
    run(1);
    tick_i = 1'b1;
    wr(S_CMP, 60);
    tick_i = 1'b0;
    rd(S_CNT, v, vl); chk("R6", "count at same-cycle ack", v, 60);
    chk("R6", "ack wins over match", int'(irq_o), 0);
    rd(S_STA, v, vl); chk("R6", "status after same-cycle ack", v, 0);

    // R8 freeze
    wr(S_CTL, 1 | (2 << 4));
    run(20);
    rd(S_CNT, v, vl); chk("R8", "frozen count", v, 60);
    wr(S_CNT, 99);
    wr(S_CMP, 100);
    run(5);
    rd(S_CNT, v, vl); chk("R8", "frozen load", v, 99);
    chk("R8", "no irq while frozen", int'(irq_o), 0);
    rd(S_CTL, v, vl); chk("R8", "control readback", v, 8'h21);
    wr(S_CTL, 2 << 4);
    run(1);
    rd(S_CNT, v, vl); chk("R8", "count resumes", v, 100);
    chk("R8", "match after unfreeze", int'(irq_o), 1 << 2);

    // R9 reroute while pending
    wr(S_CTL, 6 << 4);
    chk("R9", "rerouted line", int'(irq_o), 1 << 6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule